// File: doc/BRIEF.md
# Restoring Integer Divider

This block divides one integer by another over several clock cycles. It uses the classic restoring method. A remainder register starts out holding the dividend's magnitude. A double-width divisor register starts out holding the divisor's magnitude in its upper half. A quotient register collects one bit per step. On every step the divisor is tried against the remainder. If the difference is non-negative, it is kept and a 1 enters the quotient. Otherwise the old remainder is kept and a 0 enters the quotient. The divisor register then moves right by one bit. An operation always takes W+1 such steps.

A 2-bit operation code selects one of four results: signed quotient, unsigned quotient, signed remainder or unsigned remainder. Signed operations work on magnitudes and correct the signs at the end. The quotient rounds toward zero, and a nonzero remainder carries the dividend's sign. The unit never raises an exception. A zero divisor and the signed overflow case (most negative value divided by minus one) each produce a fixed result.

Operands enter through a valid/ready port and the result leaves through a second valid/ready port. `in_ready` is high only while the unit is idle, and an operand set is taken on a clock edge where `in_valid` and `in_ready` are both high. The result is presented with `out_valid`. It stays unchanged for as long as `out_ready` is low, so the consumer can apply back-pressure for any number of cycles. No new operand is taken until the result has been handed over. `busy` is a plain status pin that is high while the step sequence runs.

Top module: `restoring_divider`

## Requirements
- R1: `in_ready` is high exactly when the unit is idle. Operands are accepted on a rising edge with `in_valid` and `in_ready` both high, and `in_ready` is low in the cycle after an acceptance.
- R2: `out_valid` rises W+1 clock cycles after the accepting edge (65 for W=64). It stays high until the edge on which `out_ready` is high, after which the unit is idle.
- R3: While `out_valid` is high and `out_ready` is low, `out_data` holds its value from one cycle to the next.
- R4: Operation code 2'b01 returns the unsigned quotient and 2'b11 returns the unsigned remainder, with both operands taken as unsigned. The partial remainder after each step stays below the divisor register it was tried against.
- R5: Operation code 2'b00 returns the signed quotient, truncated toward zero.
- R6: Operation code 2'b10 returns the signed remainder. A nonzero result has the sign of the dividend, and its magnitude is below the divisor's magnitude.
- R7: With a zero divisor, the quotient operations (2'b00, 2'b01) return all ones and the remainder operations (2'b10, 2'b11) return the dividend unchanged.
- R8: A signed division of the most negative value (only the MSB set) by all ones returns the dividend for 2'b00 and zero for 2'b10.
- R9: During and right after reset, `in_ready` is high, `out_valid` is low and `busy` is low.
- R10: `busy` is high exactly during the W+1 step cycles. `in_valid` is ignored while busy, so operands presented then do not change the pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set is valid |
| in_ready | output | 1 | Unit is idle and will take operands |
| in_dividend | input | W | Dividend |
| in_divisor | input | W | Divisor |
| in_op | input | 2 | 00 signed quotient, 01 unsigned quotient, 10 signed remainder, 11 unsigned remainder |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | W | Result |
| busy | output | 1 | Step sequence running |

## Verification
The bench builds the divider with W=8. At that width the most negative value, the all-ones divisor and zero divisors are easy to aim at. Random operands also reach every sign combination and the cases where the quotient comes out near its limits. The narrow width also keeps each operation to nine step cycles, so many operations fit in one run, each with a different back-pressure delay and with junk operands presented while the unit is busy. A behavioural model computes every result with ordinary integer division. It tracks the handshake state cycle by cycle, and the bench compares that state against `in_ready`, `busy`, `out_valid` and `out_data` on every clock.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    OP_QUO_S = 2'b00,
    OP_QUO_U = 2'b01,
    OP_REM_S = 2'b10,
    OP_REM_U = 2'b11
  } div_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_DONE = 2'b10
  } div_state_e;
endpackage

// File: rtl/div_prep.sv
module div_prep
  import div_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  input  div_op_e      op,
  output logic [W-1:0] mag_dvd,
  output logic [W-1:0] mag_dvs,
  output logic         flip_quo,
  output logic         flip_rem,
  output logic         dvs_zero,
  output logic         sgn_ovf
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic is_signed;
  logic dvd_neg;
  logic dvs_neg;

  always_comb begin
    is_signed = ~op[0];
    dvd_neg   = is_signed & dvd[W-1];
    dvs_neg   = is_signed & dvs[W-1];
    mag_dvd   = dvd_neg ? (~dvd + 1'b1) : dvd;
    mag_dvs   = dvs_neg ? (~dvs + 1'b1) : dvs;
    flip_quo  = dvd_neg ^ dvs_neg;
    flip_rem  = dvd_neg;
    dvs_zero  = (dvs == '0);
    sgn_ovf   = is_signed & (dvd == MOST_NEG) & (&dvs);
  end
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int W = 64
) (
  input  logic [2*W-1:0] rem_in,
  input  logic [2*W-1:0] dvs_in,
  input  logic [W-1:0]   quo_in,
  output logic [2*W-1:0] rem_out,
  output logic [2*W-1:0] dvs_out,
  output logic [W-1:0]   quo_out
);
  logic [2*W:0] diff;
  logic         keep;

  always_comb begin
    diff    = {1'b0, rem_in} - {1'b0, dvs_in};
    keep    = ~diff[2*W];
    rem_out = keep ? diff[2*W-1:0] : rem_in;
    quo_out = (quo_in << 1) | {{(W-1){1'b0}}, keep};
    dvs_out = dvs_in >> 1;
  end
endmodule

// File: rtl/div_fix.sv
module div_fix
  import div_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] quo,
  input  logic [W-1:0] rem,
  input  logic [W-1:0] dvd,
  input  div_op_e      op,
  input  logic         flip_quo,
  input  logic         flip_rem,
  input  logic         dvs_zero,
  input  logic         sgn_ovf,
  output logic [W-1:0] result
);
  logic want_rem;
  logic [W-1:0] quo_s;
  logic [W-1:0] rem_s;

  always_comb begin
    want_rem = op[1];
    quo_s    = flip_quo ? (~quo + 1'b1) : quo;
    rem_s    = flip_rem ? (~rem + 1'b1) : rem;
    if (dvs_zero)      result = want_rem ? dvd : '1;
    else if (sgn_ovf)  result = want_rem ? '0 : dvd;
    else               result = want_rem ? rem_s : quo_s;
  end
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider
  import div_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_dividend,
  input  logic [W-1:0] in_divisor,
  input  logic [1:0]   in_op,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         busy
);
  localparam int STEPS = W + 1;
  localparam int CW    = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  div_state_e     state;
  logic [CW-1:0]  step_cnt;
  logic [2*W-1:0] rem_r, dvs_r;
  logic [W-1:0]   quo_r, dvd_r;
  div_op_e        op_r;
  logic           flip_quo_r, flip_rem_r, zero_r, ovf_r;

  logic [W-1:0]   mag_dvd, mag_dvs;
  logic           flip_quo, flip_rem, dvs_zero, sgn_ovf;
  logic [2*W-1:0] rem_nx, dvs_nx;
  logic [W-1:0]   quo_nx;
  logic           accept;

  div_prep #(.W(W)) u_prep (
    .dvd(in_dividend), .dvs(in_divisor), .op(div_op_e'(in_op)),
    .mag_dvd(mag_dvd), .mag_dvs(mag_dvs),
    .flip_quo(flip_quo), .flip_rem(flip_rem),
    .dvs_zero(dvs_zero), .sgn_ovf(sgn_ovf)
  );

  div_step #(.W(W)) u_step (
    .rem_in(rem_r), .dvs_in(dvs_r), .quo_in(quo_r),
    .rem_out(rem_nx), .dvs_out(dvs_nx), .quo_out(quo_nx)
  );

  div_fix #(.W(W)) u_fix (
    .quo(quo_r), .rem(rem_r[W-1:0]), .dvd(dvd_r), .op(op_r),
    .flip_quo(flip_quo_r), .flip_rem(flip_rem_r),
    .dvs_zero(zero_r), .sgn_ovf(ovf_r), .result(out_data)
  );

  assign in_ready  = (state == ST_IDLE);
  assign busy      = (state == ST_RUN);
  assign out_valid = (state == ST_DONE);
  assign accept    = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      step_cnt   <= '0;
      rem_r      <= '0;
      dvs_r      <= '0;
      quo_r      <= '0;
      dvd_r      <= '0;
      op_r       <= OP_QUO_S;
      flip_quo_r <= 1'b0;
      flip_rem_r <= 1'b0;
      zero_r     <= 1'b0;
      ovf_r      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state      <= ST_RUN;
          step_cnt   <= '0;
          rem_r      <= {{W{1'b0}}, mag_dvd};
          dvs_r      <= {mag_dvs, {W{1'b0}}};
          quo_r      <= '0;
          dvd_r      <= in_dividend;
          op_r       <= div_op_e'(in_op);
          flip_quo_r <= flip_quo;
          flip_rem_r <= flip_rem;
          zero_r     <= dvs_zero;
          ovf_r      <= sgn_ovf;
        end
        ST_RUN: begin
          rem_r    <= rem_nx;
          dvs_r    <= dvs_nx;
          quo_r    <= quo_nx;
          step_cnt <= step_cnt + 1'b1;
          if (step_cnt == LAST) state <= ST_DONE;
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Independent latency counter used only by the checks below.
  logic [CW-1:0] lat_r;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_r <= '0;
    else if (accept) lat_r <= '0;
    else if (busy)   lat_r <= lat_r + 1'b1;
  end

  // R1
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_r == CW'(STEPS)));

  // R3
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R4
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dvs_r != '0) |-> (rem_nx < dvs_r));

  // R4
  rem_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (rem_r[2*W-1:W] == '0));

  // R6
  rem_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_r == OP_REM_S && out_data != '0) |-> (out_data[W-1] == dvd_r[W-1]));
endmodule

// File: tb/sim_restoring_divider.sv
`timescale 1ns/1ps
module sim_restoring_divider;
  localparam int W = 8;
  localparam int STEPS = W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [W-1:0] in_dividend = '0;
  logic [W-1:0] in_divisor = '0;
  logic [1:0] in_op = 2'b00;
  logic in_ready, out_valid, busy;
  logic [W-1:0] out_data;

  always #2.5 clk = ~clk;

  restoring_divider #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(in_dividend), .in_divisor(in_divisor), .in_op(in_op),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .busy(busy)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  int m_st = 0;
  int m_cnt = 0;
  logic [W-1:0] m_res = '0;
  string m_tag = "R4";
  bit prev_stall = 0;
  logic [W-1:0] prev_data = '0;

  function automatic logic [W-1:0] ref_res(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] op);
    int sa, sb;
    logic [W-1:0] minv;
    minv = {1'b1, {(W-1){1'b0}}};
    sa = int'($signed(a));
    sb = int'($signed(b));
    if (b == '0) return op[1] ? a : '1;
    if (!op[0]) begin
      if (a == minv && b == '1) return op[1] ? '0 : a;
      return op[1] ? W'(sa % sb) : W'(sa / sb);
    end
    return op[1] ? (a % b) : (a / b);
  endfunction

  function automatic string ref_tag(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] op);
    if (b == '0) return "R7";
    if (!op[0] && a == {1'b1, {(W-1){1'b0}}} && b == '1) return "R8";
    if (op[0]) return "R4";
    return op[1] ? "R6" : "R5";
  endfunction

  task automatic chk(bit ok, string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model, stepped on every rising edge.
  always @(posedge clk) begin
    if (!rst_n) m_st = 0;
    else begin
      case (m_st)
        0: if (in_valid) begin
          m_st = 1; m_cnt = 0;
          m_res = ref_res(in_dividend, in_divisor, in_op);
          m_tag = ref_tag(in_dividend, in_divisor, in_op);
        end
        1: begin m_cnt++; if (m_cnt == STEPS) m_st = 2; end
        default: if (out_ready) m_st = 0;
      endcase
    end
  end

  // Per-cycle comparison on the falling edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(in_ready == (m_st == 0), "R1", "in_ready", W'(in_ready), W'(m_st == 0));
      chk(busy == (m_st == 1), "R10", "busy", W'(busy), W'(m_st == 1));
      chk(out_valid == (m_st == 2), "R2", "out_valid", W'(out_valid), W'(m_st == 2));
      if (m_st == 2) chk(out_data == m_res, m_tag, "out_data", out_data, m_res);
      if (prev_stall) chk(out_data == prev_data, "R3", "held data", out_data, prev_data);
      prev_stall = out_valid && !out_ready;
      prev_data = out_data;
    end
  end

  task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] op, int stall, bit junk);
    @(posedge clk); #1;
    while (!in_ready) begin @(posedge clk); #1; end
    in_valid = 1'b1; in_dividend = a; in_divisor = b; in_op = op;
    @(posedge clk); #1;
    if (junk) begin
      // R10: operands offered while busy must be ignored
      in_valid = 1'b1; in_dividend = ~a; in_divisor = b + 1'b1; in_op = ~op;
    end else in_valid = 1'b0;
    while (!out_valid) begin @(posedge clk); #1; end
    in_valid = 1'b0;
    repeat (stall) begin @(posedge clk); #1; end
    out_ready = 1'b1;
    @(posedge clk); #1;
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: state during reset
    chk(in_ready == 1'b1, "R9", "in_ready in reset", W'(in_ready), W'(1));
    chk(out_valid == 1'b0, "R9", "out_valid in reset", W'(out_valid), W'(0));
    chk(busy == 1'b0, "R9", "busy in reset", W'(busy), W'(0));
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R8 overflow corner
    run_op(8'h80, 8'hFF, 2'b00, 0, 0);
    run_op(8'h80, 8'hFF, 2'b10, 2, 1);
    // R7 zero divisor, all four operations
    run_op(8'h80, 8'h00, 2'b00, 0, 0);
    run_op(8'h35, 8'h00, 2'b01, 1, 1);
    run_op(8'hC3, 8'h00, 2'b10, 0, 0);
    run_op(8'hC3, 8'h00, 2'b11, 3, 0);
    // R5 / R6 sign combinations
    run_op(8'hF9, 8'h02, 2'b00, 0, 0);
    run_op(8'hF9, 8'h02, 2'b10, 0, 1);
    run_op(8'h07, 8'hFE, 2'b10, 4, 0);
    run_op(8'h80, 8'h01, 2'b00, 0, 0);
    run_op(8'h80, 8'h80, 2'b10, 0, 0);
    // R4 unsigned extremes
    run_op(8'hFF, 8'h01, 2'b01, 0, 0);
    run_op(8'hFF, 8'hFF, 2'b11, 0, 1);
    run_op(8'h05, 8'hFE, 2'b01, 5, 0);
    run_op(8'h80, 8'hFF, 2'b01, 0, 0);

    for (int i = 0; i < 80; i++) begin
      run_op(W'($urandom), W'($urandom % 5 == 0 ? 0 : $urandom), 2'($urandom),
             int'($urandom % 4), 1'($urandom));
    end

    repeat (3) @(posedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule